// File: doc/BRIEF.md
# Execute-Pair Phase Timing Sequencer

This block paces a run of mapping/streaming execute pairs on a systolic processing array. Each pair carries a vector height code and a streaming step count. The block first loads the weight vectors of the first pair. For every pair after that, it streams inputs and then fills the pipeline. While the current pair streams, it hides the weight load of the following pair. After the final pair it lets the reduction network drain once. It raises one strobe per phase, keeps a busy flag, pulses done at the end, and keeps a running count of all the cycles that do work.

A host pulses `start` while the block is idle and then offers pairs through a valid/ready port. The block asks for a pair at two points: at the start of the run, and at the beginning of every period that follows a non-final pair. The period length depends on the next pair's vector height, so the block needs that pair before the period can begin. If no pair is offered, the block waits in a named wait state and these cycles are not counted.

The states are IDLE, GET_FIRST, LOAD, GET_NEXT, RUN and DRAIN. The transitions are:
- IDLE→GET_FIRST on start.
- GET_FIRST→LOAD on an accepted pair.
- LOAD→RUN when the loaded pair is final; LOAD→GET_NEXT when it is not.
- GET_NEXT→RUN on an accepted pair.
- RUN→RUN when a non-final period ends and the held next pair is final.
- RUN→GET_NEXT when a non-final period ends and the held next pair is not final.
- RUN→DRAIN when the final pair's period ends.
- DRAIN→IDLE after the drain, with done pulsed.

Top module: `exec_pair_sequencer`

## Requirements
- R1: While reset is held, and after it is released, busy, done, pair_ready, every phase strobe and total_cycles are all 0.
- R2: A start pulse in IDLE clears total_cycles and raises busy on the next cycle. A start pulse while busy has no effect on the sequence or on the count.
- R3: pair_vn carries vector height minus one, so vn = pair_vn + 1. After the first pair is accepted, ph_wload stays high for exactly vn×vn cycles before any streaming begins.
- R4: In every pair's period, ph_stream is high for the first T×vn cycles. ph_fill is high for the next vn cycles. Together these make nest = T×vn + vn.
- R5: A non-final pair's period lasts max(nest, vn_next×vn_next − vn_next) cycles, where vn_next belongs to the following pair. ph_wload is high during the first vn_next×vn_next − vn_next cycles of that period. Cycles past nest have no stream or fill.
- R6: pair_ready is high only in GET_FIRST and GET_NEXT. In those waits no strobe is high and total_cycles holds. GET_NEXT is entered only when the current pair is not final.
- R7: The final pair's period lasts its own nest. It is followed by exactly one drain of 2×ceil(log2(ARRAY_W)) cycles with ph_drain high.
- R8: done is high for one cycle, the cycle after the last drain cycle, with busy low. total_cycles then equals: first vn² + the sum of the non-final periods + the last nest + the drain. It holds that value until the next start.
- R9: total_cycles rises by one after each cycle in which any phase strobe is high, and at no other time during a run.
- R10: ph_stream, ph_fill and ph_drain are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (used only in IDLE) |
| pair_valid | input | 1 | A pair is offered |
| pair_ready | output | 1 | Block accepts a pair this cycle |
| pair_vn | input | VN_W | Vector height minus one |
| pair_t | input | T_W | Streaming steps of the pair |
| pair_last | input | 1 | Offered pair is the final one |
| ph_wload | output | 1 | Weight-load phase (first pair or hidden next load) |
| ph_stream | output | 1 | Input streaming phase |
| ph_fill | output | 1 | Pipeline fill phase |
| ph_drain | output | 1 | Reduction-network drain |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| total_cycles | output | CYC_W | Counted cycles of the current or last run |

## Verification
The bench attacks four corner cases.
- A hidden load longer than the compute time (vn_next² − vn_next > nest). A design that took nest alone would end the period early and leave ph_wload high while stream and fill are already low.
- A vector height of one, where the hidden load is zero, and T = 0, where the period is pure fill. Off-by-one period logic breaks here.
- Gaps in pair_valid. These check that wait cycles are not counted and that the drain runs only once.
- A start pulse during a run, which a careless design would take as a restart that clears the count.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GET_FIRST,
        S_LOAD,
        S_GET_NEXT,
        S_RUN,
        S_DRAIN
    } seq_state_t;

endpackage

// File: rtl/tseq_len_calc.sv
module tseq_len_calc #(
    parameter int VN_W  = 4,
    parameter int T_W   = 8,
    parameter int LEN_W = 18
) (
    input  logic [VN_W-1:0]  vn_code,
    input  logic [T_W-1:0]   steps,
    output logic [LEN_W-1:0] load_len,
    output logic [LEN_W-1:0] stream_len,
    output logic [LEN_W-1:0] nest_len,
    output logic [LEN_W-1:0] hide_len
);
    logic [LEN_W-1:0] vn;

    assign vn         = LEN_W'(vn_code) + LEN_W'(1);
    assign load_len   = vn * vn;
    assign stream_len = LEN_W'(steps) * vn;
    assign nest_len   = stream_len + vn;
    assign hide_len   = load_len - vn;
endmodule

// File: rtl/tseq_cycle_total.sv
module tseq_cycle_total #(
    parameter int CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CYC_W-1:0] total
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total <= '0;
        end else if (clear) begin
            total <= '0;
        end else if (inc) begin
            total <= total + CYC_W'(1);
        end
    end
endmodule

// File: rtl/exec_pair_sequencer.sv
module exec_pair_sequencer
    import tseq_pkg::*;
#(
    parameter int ARRAY_W = 16,
    parameter int VN_W    = 4,
    parameter int T_W     = 8,
    parameter int CYC_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             pair_valid,
    output logic             pair_ready,
    input  logic [VN_W-1:0]  pair_vn,
    input  logic [T_W-1:0]   pair_t,
    input  logic             pair_last,
    output logic             ph_wload,
    output logic             ph_stream,
    output logic             ph_fill,
    output logic             ph_drain,
    output logic             busy,
    output logic             done,
    output logic [CYC_W-1:0] total_cycles
);
    localparam int LEN_W     = T_W + 2 * VN_W + 2;
    localparam int DRAIN_LEN = 2 * $clog2(ARRAY_W);

    seq_state_t state_q, state_d;

    // held pair descriptors
    logic [VN_W-1:0]  cur_vn, nxt_vn;
    logic [T_W-1:0]   cur_t, nxt_t;
    logic             cur_last, nxt_last;
    logic [LEN_W-1:0] period_q;
    logic [LEN_W-1:0] k_q;
    logic             done_q;

    logic [LEN_W-1:0] in_load, in_stream, in_nest, in_hide;
    logic [LEN_W-1:0] cur_load, cur_stream, cur_nest, cur_hide;
    logic [LEN_W-1:0] nxt_load, nxt_stream, nxt_nest, nxt_hide;
    logic [LEN_W-1:0] next_period;

    logic pair_fire;
    logic counted;
    logic k_last;
    logic run_clear;

    tseq_len_calc #(.VN_W(VN_W), .T_W(T_W), .LEN_W(LEN_W)) i_len_in (
        .vn_code(pair_vn), .steps(pair_t),
        .load_len(in_load), .stream_len(in_stream),
        .nest_len(in_nest), .hide_len(in_hide)
    );

    tseq_len_calc #(.VN_W(VN_W), .T_W(T_W), .LEN_W(LEN_W)) i_len_cur (
        .vn_code(cur_vn), .steps(cur_t),
        .load_len(cur_load), .stream_len(cur_stream),
        .nest_len(cur_nest), .hide_len(cur_hide)
    );

    tseq_len_calc #(.VN_W(VN_W), .T_W(T_W), .LEN_W(LEN_W)) i_len_nxt (
        .vn_code(nxt_vn), .steps(nxt_t),
        .load_len(nxt_load), .stream_len(nxt_stream),
        .nest_len(nxt_nest), .hide_len(nxt_hide)
    );

    assign pair_ready  = (state_q == S_GET_FIRST) || (state_q == S_GET_NEXT);
    assign pair_fire   = pair_valid && pair_ready;
    assign counted     = (state_q == S_LOAD) || (state_q == S_RUN) || (state_q == S_DRAIN);
    assign run_clear   = (state_q == S_IDLE) && start;
    assign next_period = (cur_nest > in_hide) ? cur_nest : in_hide;

    // end of the current counted phase
    always_comb begin
        unique case (state_q)
            S_LOAD:  k_last = (k_q == cur_load - LEN_W'(1));
            S_RUN:   k_last = (k_q == period_q - LEN_W'(1));
            S_DRAIN: k_last = (k_q == LEN_W'(DRAIN_LEN - 1));
            default: k_last = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_d = S_GET_FIRST;
            S_GET_FIRST: if (pair_fire) state_d = S_LOAD;
            S_LOAD:      if (k_last) state_d = cur_last ? S_RUN : S_GET_NEXT;
            S_GET_NEXT:  if (pair_fire) state_d = S_RUN;
            S_RUN: begin
                if (k_last) begin
                    if (cur_last)      state_d = S_DRAIN;
                    else if (nxt_last) state_d = S_RUN;
                    else               state_d = S_GET_NEXT;
                end
            end
            S_DRAIN:     if (k_last) state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // phase counter, pair holding registers and period length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q      <= '0;
            cur_vn   <= '0;
            cur_t    <= '0;
            cur_last <= 1'b0;
            nxt_vn   <= '0;
            nxt_t    <= '0;
            nxt_last <= 1'b0;
            period_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (state_q == S_DRAIN) && k_last;

            if (counted && !k_last) k_q <= k_q + LEN_W'(1);
            else                    k_q <= '0;

            if ((state_q == S_GET_FIRST) && pair_fire) begin
                cur_vn   <= pair_vn;
                cur_t    <= pair_t;
                cur_last <= pair_last;
            end

            if ((state_q == S_LOAD) && k_last && cur_last) begin
                period_q <= cur_nest;
            end

            if ((state_q == S_GET_NEXT) && pair_fire) begin
                nxt_vn   <= pair_vn;
                nxt_t    <= pair_t;
                nxt_last <= pair_last;
                period_q <= next_period;
            end

            if ((state_q == S_RUN) && k_last && !cur_last) begin
                cur_vn   <= nxt_vn;
                cur_t    <= nxt_t;
                cur_last <= nxt_last;
                period_q <= nxt_nest;
            end
        end
    end

    tseq_cycle_total #(.CYC_W(CYC_W)) i_total (
        .clk(clk), .rst_n(rst_n),
        .clear(run_clear), .inc(counted),
        .total(total_cycles)
    );

    // outputs
    always_comb begin
        ph_wload  = 1'b0;
        ph_stream = 1'b0;
        ph_fill   = 1'b0;
        ph_drain  = 1'b0;
        unique case (state_q)
            S_LOAD:  ph_wload = 1'b1;
            S_RUN: begin
                ph_wload  = !cur_last && (k_q < nxt_hide);
                ph_stream = (k_q < cur_stream);
                ph_fill   = (k_q >= cur_stream) && (k_q < cur_nest);
            end
            S_DRAIN: ph_drain = 1'b1;
            default: ;
        endcase
    end

    assign busy = (state_q != S_IDLE);
    assign done = done_q;

endmodule

// File: rtl/tseq_checker.sv
module tseq_checker #(
    parameter int CYC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             pair_ready,
    input logic             ph_wload,
    input logic             ph_stream,
    input logic             ph_fill,
    input logic             ph_drain,
    input logic             busy,
    input logic             done,
    input logic [CYC_W-1:0] total_cycles
);
    logic any_ph;
    assign any_ph = ph_wload || ph_stream || ph_fill || ph_drain;

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ph_stream, ph_fill, ph_drain}));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(total_cycles));

    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any_ph |=> (total_cycles == $past(total_cycles) + CYC_W'(1)));

    p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !any_ph) |=> $stable(total_cycles));

    p_ready_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ready |-> (busy && !any_ph));

    p_drain_after_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_drain) |-> $past(ph_fill));
endmodule

bind exec_pair_sequencer tseq_checker #(.CYC_W(CYC_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .pair_ready(pair_ready),
    .ph_wload(ph_wload), .ph_stream(ph_stream), .ph_fill(ph_fill),
    .ph_drain(ph_drain), .busy(busy), .done(done),
    .total_cycles(total_cycles)
);

// File: tb/test_exec_pair_sequencer.sv
`timescale 1ns/1ps
module test_exec_pair_sequencer;
    localparam int AW    = 16;
    localparam int VN_W  = 4;
    localparam int T_W   = 8;
    localparam int CYC_W = 32;
    localparam int DRAIN = 2 * $clog2(AW);

    localparam int M_IDLE = 0, M_FIRST = 1, M_LOAD = 2, M_NEXT = 3, M_RUN = 4, M_DRAIN = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic pair_valid = 1'b0;
    logic pair_ready;
    logic [VN_W-1:0] pair_vn = '0;
    logic [T_W-1:0]  pair_t = '0;
    logic pair_last = 1'b0;
    logic ph_wload, ph_stream, ph_fill, ph_drain, busy, done;
    logic [CYC_W-1:0] total_cycles;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;
    logic acc = 1'b0;

    int p_vn[8];
    int p_t[8];

    always #10 clk = ~clk;

    exec_pair_sequencer #(.ARRAY_W(AW), .VN_W(VN_W), .T_W(T_W), .CYC_W(CYC_W)) i_exec_pair_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .pair_valid(pair_valid),
        .pair_ready(pair_ready), .pair_vn(pair_vn), .pair_t(pair_t),
        .pair_last(pair_last), .ph_wload(ph_wload), .ph_stream(ph_stream),
        .ph_fill(ph_fill), .ph_drain(ph_drain), .busy(busy), .done(done),
        .total_cycles(total_cycles)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_mode = M_IDLE;
    int m_k = 0;
    int m_period = 0;
    longint m_total = 0;
    bit m_done = 0;
    int c_vn = 1, c_t = 0, n_vn = 1, n_t = 0;
    bit c_last = 0, n_last = 0;

    always @(posedge clk) begin
        acc <= pair_valid && pair_ready;
        if (!rst_n) begin
            m_mode = M_IDLE; m_k = 0; m_total = 0; m_done = 0; c_last = 0;
        end else begin
            m_done = 0;
            case (m_mode)
                M_IDLE: if (start) begin m_mode = M_FIRST; m_total = 0; end
                M_FIRST: if (pair_valid) begin
                    c_vn = int'(pair_vn) + 1; c_t = int'(pair_t); c_last = pair_last;
                    m_mode = M_LOAD; m_k = 0;
                end
                M_LOAD: begin
                    m_total++; m_k++;
                    if (m_k == c_vn * c_vn) begin
                        m_k = 0;
                        if (c_last) begin m_period = c_t * c_vn + c_vn; m_mode = M_RUN; end
                        else m_mode = M_NEXT;
                    end
                end
                M_NEXT: if (pair_valid) begin
                    n_vn = int'(pair_vn) + 1; n_t = int'(pair_t); n_last = pair_last;
                    m_period = c_t * c_vn + c_vn;
                    if (n_vn * n_vn - n_vn > m_period) m_period = n_vn * n_vn - n_vn;
                    m_mode = M_RUN; m_k = 0;
                end
                M_RUN: begin
                    m_total++; m_k++;
                    if (m_k == m_period) begin
                        m_k = 0;
                        if (c_last) m_mode = M_DRAIN;
                        else begin
                            c_vn = n_vn; c_t = n_t; c_last = n_last;
                            if (c_last) begin m_period = c_t * c_vn + c_vn; m_mode = M_RUN; end
                            else m_mode = M_NEXT;
                        end
                    end
                end
                M_DRAIN: begin
                    m_total++; m_k++;
                    if (m_k == DRAIN) begin m_k = 0; m_mode = M_IDLE; m_done = 1; end
                end
                default: m_mode = M_IDLE;
            endcase
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_wl;
            e_wl = (m_mode == M_LOAD) ||
                   (m_mode == M_RUN && !c_last && m_k < n_vn * n_vn - n_vn);
            chk("R2 busy", busy, m_mode != M_IDLE);
            chk("R6 pair_ready", pair_ready, m_mode == M_FIRST || m_mode == M_NEXT);
            chk(m_mode == M_RUN ? "R5 ph_wload" : "R3 ph_wload", ph_wload, e_wl);
            chk("R4 ph_stream", ph_stream, m_mode == M_RUN && m_k < c_t * c_vn);
            chk("R4 ph_fill", ph_fill,
                m_mode == M_RUN && m_k >= c_t * c_vn && m_k < c_t * c_vn + c_vn);
            chk("R7 ph_drain", ph_drain, m_mode == M_DRAIN);
            chk("R8 done", done, m_done);
            chk("R9 total_cycles", total_cycles, m_total);
            chk("R10 strobe exclusivity", (int'(ph_stream) + int'(ph_fill) + int'(ph_drain)) <= 1, 1);
        end
    end

    function automatic longint formula(input int n);
        longint s;
        int v, vx, nest, hid;
        v = p_vn[0] + 1;
        s = v * v;
        for (int i = 0; i < n - 1; i++) begin
            v = p_vn[i] + 1;
            nest = p_t[i] * v + v;
            vx = p_vn[i + 1] + 1;
            hid = vx * vx - vx;
            s += (nest > hid) ? nest : hid;
        end
        v = p_vn[n - 1] + 1;
        s += p_t[n - 1] * v + v + DRAIN;
        return s;
    endfunction

    task automatic send(input int vnf, input int t, input bit last);
        pair_vn = VN_W'(vnf); pair_t = T_W'(t); pair_last = last; pair_valid = 1'b1;
        do @(negedge clk); while (!acc);
        pair_valid = 1'b0;
    endtask

    task automatic do_run(input int n, input int gap, input bit poke);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < n; i++) begin
            repeat (gap) @(negedge clk);
            send(p_vn[i], p_t[i], i == n - 1);
            if (poke && i == 0) begin
                start = 1'b1; @(negedge clk); start = 1'b0;
            end
        end
        while (!done) @(negedge clk);
        chk("R8 total at done", total_cycles, formula(n));
        repeat (4) @(negedge clk);
        chk("R8 total holds", total_cycles, formula(n));
        chk("R8 idle after done", busy, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 200000 && !finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 200000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 ready in reset", pair_ready, 0);
        chk("R1 strobes in reset", {ph_wload, ph_stream, ph_fill, ph_drain}, 0);
        chk("R1 done in reset", done, 0);
        chk("R1 total in reset", total_cycles, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", busy, 0);

        // single final pair: vn=3, T=4 -> 9 + 15 + drain
        p_vn[0] = 2; p_t[0] = 4;
        do_run(1, 0, 0);
        chk("R7 single-pair total", total_cycles, 9 + 15 + DRAIN);

        // three pairs, hidden load dominates first period, vn=1 tail
        p_vn[0] = 1; p_t[0] = 3;
        p_vn[1] = 3; p_t[1] = 1;
        p_vn[2] = 0; p_t[2] = 5;
        do_run(3, 0, 0);
        chk("R5 three-pair total", total_cycles, 38);

        // same pairs with gaps: waits are not counted
        do_run(3, 3, 0);
        chk("R6 gaps leave total unchanged", total_cycles, 38);

        // start during the run is ignored
        do_run(3, 1, 1);
        chk("R2 start while busy ignored", total_cycles, 38);

        // largest vector height, no streaming steps
        p_vn[0] = 15; p_t[0] = 0;
        do_run(1, 0, 0);
        chk("R3 max height load", total_cycles, 256 + 16 + DRAIN);

        // longer chain with mixed heights and T=0
        p_vn[0] = 3; p_t[0] = 0;
        p_vn[1] = 7; p_t[1] = 2;
        p_vn[2] = 2; p_t[2] = 0;
        p_vn[3] = 4; p_t[3] = 9;
        p_vn[4] = 1; p_t[4] = 1;
        do_run(5, 2, 0);

        // a new start clears the count (R2)
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R2 start clears total", total_cycles, 0);
        chk("R2 busy after start", busy, 1);
        p_vn[0] = 0; p_t[0] = 0;
        send(0, 0, 1);
        while (!done) @(negedge clk);
        chk("R8 minimal run total", total_cycles, 1 + 1 + DRAIN);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule